// File: doc/BRIEF.md
# Sub-Block Orientation Descriptor Accumulator

This block turns a 16x16 patch of gradient samples around a key-point into a 128-value descriptor vector. Each sample arrives already reduced to a gradient magnitude and a 32-level orientation code. The block keeps its own position counter, so samples must arrive in raster order: row by row, left to right. A cycle with `in_valid` low is a gap and does not advance the position.

The patch is cut into a 4x4 grid of 4x4-pixel tiles. Each sample's position selects its tile. Its orientation code is coarsened to one of eight bins, and its magnitude is added into that bin of the tile's histogram.

When the 256th sample has been taken, the block plays out all sixteen histograms, one value per clock. Each entry is cleared as it leaves, so the next patch starts from empty histograms.

Top module: `sbd_accum`

## Requirements
- R1: After reset `out_valid` and `out_last` are low, and every histogram entry is zero, so a patch of all-zero magnitudes yields 128 zero values.
- R2: A sample's position is its count within the patch, from 0 to 255. Its row is position/16 and its column is position mod 16. Its tile index is (row/4)*4 + (column/4).
- R3: The 5-bit orientation code is coarsened to a 3-bit bin equal to its top three bits (code/4).
- R4: Each bin holds the exact sum of the magnitudes routed to it, in 12 bits. The largest case is sixteen samples of 255 in one bin, which gives 4080.
- R5: Play-out begins in the cycle after the clock edge that takes the 256th sample. `out_valid` then stays high for exactly 128 consecutive cycles.
- R6: Output value k, for k from 0 to 127, is bin (k mod 8) of tile (k/8).
- R7: `out_last` is high only together with the 128th value, and `out_valid` is low in the following cycle.
- R8: Samples offered while play-out is running are ignored. They neither add to any histogram nor advance the position.
- R9: When play-out ends, all histograms are zero, so nothing carries over from one patch to the next.
- R10: Cycles with `in_valid` low between samples neither move the position nor change any histogram.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this cycle |
| in_mag | input | 8 | Gradient magnitude of the sample |
| in_bin | input | 5 | 32-level orientation code of the sample |
| out_valid | output | 1 | Descriptor value present |
| out_data | output | 12 | Descriptor value (bin sum) |
| out_last | output | 1 | Marks the 128th descriptor value |

## Verification
A sample is added to its histogram at the clock edge that takes it. Descriptor value k is therefore on the outputs k+1 cycles after the edge that takes the 256th sample, and `out_valid` falls 129 cycles after that edge. The bench drives inputs on falling edges and reads the outputs on the falling edge that follows each due rising edge. This means every check looks at a settled value in exactly the cycle it is due. A position sweep places one marked sample at each of the 256 positions in turn, which pins the routing and the output order for every tile and every bin. Further patches cover gaps, maximal sums and junk offered during play-out.

// File: rtl/sbd_accum.sv
module sbd_accum #(
  parameter int MAG_W     = 8,
  parameter int IN_BIN_W  = 5,
  parameter int OUT_BIN_W = 3,
  parameter int TILE      = 4,
  parameter int GRID      = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic [MAG_W-1:0]                       in_mag,
  input  logic [IN_BIN_W-1:0]                    in_bin,
  output logic                                   out_valid,
  output logic [MAG_W+$clog2(TILE*TILE)-1:0]     out_data,
  output logic                                   out_last
);
  localparam int WIN    = TILE * GRID;
  localparam int NPIX   = WIN * WIN;
  localparam int NBINS  = 1 << OUT_BIN_W;
  localparam int NVAL   = GRID * GRID * NBINS;
  localparam int ACC_W  = MAG_W + $clog2(TILE * TILE);
  localparam int POS_W  = $clog2(NPIX);
  localparam int LINE_W = $clog2(WIN);
  localparam int SH     = $clog2(TILE);
  localparam int IDX_W  = $clog2(NVAL);

  logic [ACC_W-1:0] hist [NVAL];
  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] rd_idx;
  logic             dumping;

  wire [LINE_W-1:0]    row  = pos[POS_W-1:LINE_W];
  wire [LINE_W-1:0]    col  = pos[LINE_W-1:0];
  wire [OUT_BIN_W-1:0] obin = in_bin[IN_BIN_W-1 -: OUT_BIN_W];
  wire [IDX_W-1:0]     wr_idx = {row[LINE_W-1:SH], col[LINE_W-1:SH], obin};
  wire                 take = in_valid && !dumping;

  assign out_valid = dumping;
  assign out_data  = hist[rd_idx];
  assign out_last  = dumping && (rd_idx == IDX_W'(NVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVAL; i++) hist[i] <= '0;
      pos     <= '0;
      rd_idx  <= '0;
      dumping <= 1'b0;
    end else if (dumping) begin
      hist[rd_idx] <= '0;
      rd_idx       <= rd_idx + 1'b1;
      if (rd_idx == IDX_W'(NVAL - 1)) dumping <= 1'b0;
    end else if (take) begin
      hist[wr_idx] <= hist[wr_idx] + ACC_W'(in_mag);
      pos          <= pos + 1'b1;
      if (pos == POS_W'(NPIX - 1)) dumping <= 1'b1;
    end
  end

  logic any_nz;
  always_comb begin
    any_nz = 1'b0;
    for (int i = 0; i < NVAL; i++) any_nz = any_nz | (|hist[i]);
  end

  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  // R7
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R8
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pos == '0));
  // R9
  cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !any_nz);
  // R10
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !out_valid) |=> $stable(pos));
endmodule

// File: tb/sbd_accum_tb.sv
module sbd_accum_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_mag = '0;
  logic [4:0] in_bin = '0;
  logic out_valid, out_last;
  logic [11:0] out_data;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  int exp_v [128];
  int smag [256];
  int sbin [256];

  always #2.5 clk = ~clk;

  sbd_accum u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mag(in_mag),
                   .in_bin(in_bin), .out_valid(out_valid), .out_data(out_data),
                   .out_last(out_last));

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int dest(input int p, input int b);
    int r = p / 16, c = p % 16;
    return ((r / 4) * 4 + (c / 4)) * 8 + (b / 4);
  endfunction

  task automatic build_exp();
    for (int k = 0; k < 128; k++) exp_v[k] = 0;
    for (int p = 0; p < 256; p++) exp_v[dest(p, sbin[p])] += smag[p];
  endtask

  // gaps: insert an idle cycle before every third sample; junk: offer samples during play-out
  task automatic run_window(input bit gaps, input bit junk, input string tag);
    build_exp();
    for (int p = 0; p < 256; p++) begin
      if (gaps && (p % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_mag = 8'hFF; in_bin = 5'd31;
      end
      @(negedge clk);
      in_valid = 1'b1; in_mag = 8'(smag[p]); in_bin = 5'(sbin[p]);
    end
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      in_valid = junk; in_mag = 8'(200 + k % 50); in_bin = 5'(k % 32);
      check({tag, " R5 valid"}, int'(out_valid), 1);
      check({tag, " R6 R4 value"}, int'(out_data), exp_v[k]);
      check({tag, " R7 last"}, int'(out_last), (k == 127) ? 1 : 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R7 valid drops"}, int'(out_valid), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_last", int'(out_last), 0);
    rst_n = 1'b1;
    // R1: zero patch reads back all zero
    for (int p = 0; p < 256; p++) begin smag[p] = 0; sbin[p] = p % 32; end
    run_window(0, 0, "R1 zero");
    // R2 R3 R6: one marked sample per patch, at every position
    for (int q = 0; q < 256; q++) begin
      for (int p = 0; p < 256; p++) begin smag[p] = 0; sbin[p] = 0; end
      smag[q] = (q % 255) + 1;
      sbin[q] = (q * 7) % 32;
      run_window(0, 0, "R2 R3 sweep");
    end
    // R4: maximal sum in one bin
    for (int p = 0; p < 256; p++) begin smag[p] = 255; sbin[p] = 31; end
    run_window(0, 0, "R4 max");
    // R10: mixed pattern with idle gaps, R8: junk offered during play-out
    for (int p = 0; p < 256; p++) begin
      smag[p] = (p * 37 + 11) % 256; sbin[p] = (p * 3 + (p / 16) * 5) % 32;
    end
    run_window(1, 1, "R10 R8 mixed");
    // R9 R8: next patch must not see residue or junk
    for (int p = 0; p < 256; p++) begin smag[p] = (p % 5) + 1; sbin[p] = (p / 8) % 32; end
    run_window(0, 0, "R9 fresh");
    finish_run();
  end
endmodule